// File: doc/BRIEF.md
# Bidirectional Round-Key Generator

This block produces one 48-bit round key per round for a 96-bit Feistel-style cipher whose data path lives elsewhere. It keeps a 96-bit key state split into a right half and a left half, each made of six 8-bit words, plus a round counter and a direction flag. The active half is always presented on the round-key output. Each advance strobe derives a new value for the other half from the active half, using the same three-word nonlinear substitution that the cipher data path uses, and then the halves trade roles.

The counter counts up from 1. When the counter stands at the middle round, the upward update is skipped. The direction turns to down and the schedule continues with a decrementing counter. Each downward update rewrites the half that was just used, from the half about to be used. The schedule runs for 2·MID−1 rounds and ends when the counter returns to 1 in the downward direction. After that the state is frozen until the next load. A load installs a fresh 96-bit key at any time and takes priority over an advance in the same cycle.

Top module: `bks_sched`

## Requirements
- R1: After reset both halves are zero, the counter is 1, the direction is up (`down_o` = 0) and `rkey_o` is zero.
- R2: A load sets the right half from `key_i[47:0]` and the left half from `key_i[95:48]`, sets the counter to 1 and the direction to up, and makes the right half active. The new state is visible one cycle later. A load wins over a simultaneous advance.
- R3: `rkey_o` shows the active half. Rounds are counted from 1 at load. The right half is active on odd rounds and the left half on even rounds, and every accepted advance exchanges the roles.
- R4: The substitution takes three 8-bit words a, b, c, where word k of a half is bits [8k+7:8k]. It computes x = (c AND b) XOR a, y = (c AND x) XOR b and z = (y OR x) XOR c. Its outputs are x rotated right by 1, y, and z rotated left by 1. Words 0–2 form one group and words 3–5 the other.
- R5: Only word 0 of the source half has the counter added to it, modulo 256, before substitution. Output j is XORed into word (j+1) mod 6 of the target half. For example, an all-zero key gives the round-2 key 48'h000002008000.
- R6: In the up direction with the counter below 47, an advance XORs the substitution of the active half, using the counter value, into the inactive half. It then increments the counter.
- R7: In the up direction with the counter at 47, an advance skips the upward update. It sets the direction to down and the counter to 46, and XORs the substitution of the other half, using 46, into the half just used.
- R8: In the down direction with the counter above 1, an advance decrements the counter. It then XORs the substitution of the other half, using the new counter value, into the half just used.
- R9: In the down direction with the counter at 1, which is round 93, an advance leaves the round key, counter and direction unchanged.
- R10: With neither load nor advance asserted, the round key, counter and direction hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Install `key_i` and restart the schedule |
| key_i | input | 96 | Initial key: [47:0] right half, [95:48] left half |
| adv_i | input | 1 | Advance the schedule by one round |
| rkey_o | output | 48 | Round key of the current round (active half) |
| cnt_o | output | 7 | Round counter |
| down_o | output | 1 | Direction: 0 counts up, 1 counts down |

## Verification
The hardest state to reach from the ports is the tail of the schedule: the turn at counter 47 and the terminal hold at counter 1 in the down direction. Both need 46 or 92 consecutive advances with no intervening load. The stimulus drives complete runs of 100 advances from random keys and from directed keys (all zeros, all ones). It scatters random idle cycles between the advances and compares every round against a bench model. The run therefore crosses the midpoint several times and pushes advances past the end of the schedule. A load issued in the same cycle as an advance, part-way through a run, checks the priority rule.

// File: rtl/bks_pkg.sv
package bks_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } bks_dir_e;

    typedef enum logic {
        SIDE_RIGHT = 1'b0,
        SIDE_LEFT  = 1'b1
    } bks_side_e;

endpackage

// File: rtl/bks_sub3.sv
// Three-word nonlinear substitution shared with the cipher data path.
module bks_sub3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] o0_o,
    output logic [W-1:0] o1_o,
    output logic [W-1:0] o2_o
);
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W-1:0] z;

    always_comb begin
        x    = (c_i & b_i) ^ a_i;
        y    = (c_i & x) ^ b_i;
        z    = (y | x) ^ c_i;
        o0_o = {x[0], x[W-1:1]};
        o1_o = y;
        o2_o = {z[W-2:0], z[W-1]};
    end
endmodule

// File: rtl/bks_mix.sv
// Derives the update of one key half from the other: counter injection into
// word 0, grouped substitution, output placement shifted up one word.
module bks_mix #(
    parameter int W      = 8,
    parameter int NWORDS = 6,
    parameter int CNT_W  = 7
) (
    input  logic [NWORDS*W-1:0] src_i,
    input  logic [NWORDS*W-1:0] dst_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic [NWORDS*W-1:0] nxt_o
);
    localparam int NGROUPS = NWORDS / 3;

    logic [CNT_W+W-1:0] cnt_ext;
    logic [W-1:0]       inj;
    logic [W-1:0]       sw [NWORDS];
    logic [W-1:0]       ow [NWORDS];

    assign cnt_ext = {{W{1'b0}}, cnt_i};
    assign inj     = cnt_ext[W-1:0];

    for (genvar j = 0; j < NWORDS; j++) begin : g_word
        if (j == 0) begin : g_inj
            assign sw[j] = src_i[j*W +: W] + inj;
        end else begin : g_pass
            assign sw[j] = src_i[j*W +: W];
        end
        assign nxt_o[((j + 1) % NWORDS)*W +: W] =
            dst_i[((j + 1) % NWORDS)*W +: W] ^ ow[j];
    end

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        bks_sub3 #(.W(W)) sub_i (
            .a_i  (sw[3*g]),
            .b_i  (sw[3*g+1]),
            .c_i  (sw[3*g+2]),
            .o0_o (ow[3*g]),
            .o1_o (ow[3*g+1]),
            .o2_o (ow[3*g+2])
        );
    end
endmodule

// File: rtl/bks_sched.sv
module bks_sched
    import bks_pkg::*;
#(
    parameter int W      = 8,
    parameter int NWORDS = 6,
    parameter int MID    = 47,
    parameter int HALF_W = NWORDS * W,
    parameter int CNT_W  = ($clog2(MID + 1) > 7) ? $clog2(MID + 1) : 7
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [2*HALF_W-1:0] key_i,
    input  logic                adv_i,
    output logic [HALF_W-1:0]   rkey_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                down_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(MID);

    typedef struct packed {
        logic [HALF_W-1:0] right;
        logic [HALF_W-1:0] left;
        bks_side_e         act;
        logic [CNT_W-1:0]  cnt;
        bks_dir_e          dir;
    } bks_state_t;

    bks_state_t st_d, st_q;

    logic              turn_down;
    logic              finished;
    bks_side_e         src_side;
    logic [HALF_W-1:0] mix_src;
    logic [HALF_W-1:0] mix_dst;
    logic [CNT_W-1:0]  mix_cnt;
    logic [HALF_W-1:0] mix_nxt;

    // Operand selection for the single substitution unit.
    always_comb begin
        turn_down = (st_q.dir == DIR_DOWN) || (st_q.cnt == CNT_MID);
        finished  = (st_q.dir == DIR_DOWN) && (st_q.cnt == CNT_ONE);
        src_side  = turn_down ? bks_side_e'(~st_q.act) : st_q.act;
        mix_cnt   = turn_down ? (st_q.cnt - CNT_ONE) : st_q.cnt;
        mix_src   = (src_side == SIDE_RIGHT) ? st_q.right : st_q.left;
        mix_dst   = (src_side == SIDE_RIGHT) ? st_q.left  : st_q.right;
    end

    bks_mix #(.W(W), .NWORDS(NWORDS), .CNT_W(CNT_W)) mix_i (
        .src_i (mix_src),
        .dst_i (mix_dst),
        .cnt_i (mix_cnt),
        .nxt_o (mix_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.right = key_i[HALF_W-1:0];
            st_d.left  = key_i[2*HALF_W-1:HALF_W];
            st_d.act   = SIDE_RIGHT;
            st_d.cnt   = CNT_ONE;
            st_d.dir   = DIR_UP;
        end else if (adv_i && !finished) begin
            if (src_side == SIDE_RIGHT) begin
                st_d.left = mix_nxt;
            end else begin
                st_d.right = mix_nxt;
            end
            st_d.act = bks_side_e'(~st_q.act);
            st_d.cnt = mix_cnt + (turn_down ? '0 : CNT_ONE);
            st_d.dir = turn_down ? DIR_DOWN : DIR_UP;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{right: '0, left: '0, act: SIDE_RIGHT, cnt: CNT_ONE, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign rkey_o = (st_q.act == SIDE_RIGHT) ? st_q.right : st_q.left;
    assign cnt_o  = st_q.cnt;
    assign down_o = (st_q.dir == DIR_DOWN);
endmodule

// File: rtl/bks_sched_chk.sv
module bks_sched_chk #(
    parameter int MID    = 47,
    parameter int HALF_W = 48,
    parameter int CNT_W  = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              load_i,
    input logic              adv_i,
    input logic [HALF_W-1:0] rkey_o,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              down_o
);
    a_r2_load_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_o == CNT_W'(1)) && !down_o);

    a_r6_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && adv_i && !down_o && cnt_o != CNT_W'(MID))
        |=> (cnt_o == $past(cnt_o) + CNT_W'(1)) && !down_o);

    a_r7_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && adv_i && !down_o && cnt_o == CNT_W'(MID))
        |=> down_o && (cnt_o == CNT_W'(MID - 1)));

    a_r8_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && adv_i && down_o && cnt_o != CNT_W'(1))
        |=> down_o && (cnt_o == $past(cnt_o) - CNT_W'(1)));

    a_r9_final_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && down_o && cnt_o == CNT_W'(1))
        |=> $stable(rkey_o) && $stable(cnt_o) && down_o);

    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !adv_i) |=> $stable(rkey_o) && $stable(cnt_o) && $stable(down_o));

    a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o >= CNT_W'(1)) && (cnt_o <= CNT_W'(MID)));
endmodule

bind bks_sched bks_sched_chk #(.MID(MID), .HALF_W(HALF_W), .CNT_W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_i  (adv_i),
    .rkey_o (rkey_o),
    .cnt_o  (cnt_o),
    .down_o (down_o)
);

// File: tb/bks_sched_tb.sv
module bks_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [95:0] key = '0;
    logic        adv = 1'b0;
    logic [47:0] rkey;
    logic [6:0]  cnt;
    logic        down;

    int n_chk  = 0;
    int n_fail = 0;

    // Bench model state
    logic [47:0] m_r, m_l;
    logic        m_act, m_down;
    int          m_cnt;

    always #4 clk = ~clk;

    bks_sched dut_i (
        .clk_i (clk), .rst_ni (rst_n), .load_i (load), .key_i (key),
        .adv_i (adv), .rkey_o (rkey), .cnt_o (cnt), .down_o (down)
    );

    function automatic logic [47:0] ref_f(logic [47:0] s, int c);
        logic [7:0] w [6];
        logic [7:0] o [6];
        logic [7:0] a, b, cc, x, y, z;
        logic [47:0] r;
        for (int k = 0; k < 6; k++) w[k] = s[8*k +: 8];
        for (int g = 0; g < 2; g++) begin
            a  = w[3*g] + ((g == 0) ? 8'(c) : 8'd0);
            b  = w[3*g+1];
            cc = w[3*g+2];
            x  = a ^ (b & cc);
            y  = b ^ (x & cc);
            z  = cc ^ (x | y);
            o[3*g]   = (x >> 1) | (x << 7);
            o[3*g+1] = y;
            o[3*g+2] = (z << 1) | (z >> 7);
        end
        r = '0;
        for (int j = 0; j < 6; j++) r[8*((j + 1) % 6) +: 8] = o[j];
        return r;
    endfunction

    function automatic logic [47:0] exp_key();
        return m_act ? m_l : m_r;
    endfunction

    task automatic model_load(logic [95:0] k);
        m_r = k[47:0]; m_l = k[95:48]; m_act = 1'b0; m_cnt = 1; m_down = 1'b0;
    endtask

    task automatic model_step();
        if (m_down && m_cnt == 1) begin
            // terminal hold
        end else if (!m_down && m_cnt != 47) begin
            if (!m_act) m_l = m_l ^ ref_f(m_r, m_cnt);
            else        m_r = m_r ^ ref_f(m_l, m_cnt);
            m_cnt++; m_act = ~m_act;
        end else begin
            m_down = 1'b1; m_cnt--;
            if (!m_act) m_r = m_r ^ ref_f(m_l, m_cnt);
            else        m_l = m_l ^ ref_f(m_r, m_cnt);
            m_act = ~m_act;
        end
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " rkey"}, 64'(rkey), 64'(exp_key()));
        chk({req, " cnt"},  64'(cnt),  64'(m_cnt));
        chk({req, " dir"},  64'(down), 64'(m_down));
    endtask

    task automatic do_load(logic [95:0] k, logic with_adv);
        @(negedge clk);
        key = k; load = 1'b1; adv = with_adv;
        @(negedge clk);
        load = 1'b0; adv = 1'b0;
        model_load(k);
    endtask

    task automatic do_adv(string req);
        @(negedge clk);
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
        model_step();
        chk_all(req);
    endtask

    task automatic full_run(logic [95:0] k);
        string tag;
        do_load(k, 1'b0);
        chk_all("R2 R3 load");
        for (int i = 0; i < 100; i++) begin
            if (m_down && m_cnt == 1)            tag = "R9 hold";
            else if (!m_down && m_cnt == 47)     tag = "R7 turn";
            else if (m_down)                     tag = "R8 R3 down";
            else                                 tag = "R6 R4 R3 up";
            do_adv(tag);
            if (($urandom % 8) == 0) begin
                @(negedge clk);
                chk_all("R10 idle");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_load('0);
        repeat (3) @(negedge clk);
        chk("R1 reset rkey", 64'(rkey), 64'h0);
        chk("R1 reset cnt", 64'(cnt), 64'd1);
        chk("R1 reset dir", 64'(down), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R10 idle after reset");

        // R5 directed: all-zero key, counter alone drives the update
        do_load('0, 1'b0);
        chk_all("R2 zero load");
        do_adv("R5 counter injection");
        chk("R5 literal", 64'(rkey), 64'h0000_0200_8000);

        full_run('0);
        full_run({96{1'b1}});
        for (int r = 0; r < 4; r++) begin
            full_run({$urandom, $urandom, $urandom});
        end

        // R2: load in the same cycle as an advance, mid-run
        do_load({$urandom, $urandom, $urandom}, 1'b0);
        for (int i = 0; i < 10; i++) do_adv("R6 pre");
        do_load({$urandom, $urandom, $urandom}, 1'b1);
        chk_all("R2 load beats advance");
        do_adv("R6 after reload");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule